// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a clocked request port and an external asynchronous static RAM of 128K bytes. A requester offers a read or a write through a valid/ready handshake. The block drives the 17-bit word address, an active-low and an active-high chip select, an active-low output enable and an active-low write enable. The shared 8-bit data bus is handled as three separate signals: data out, data in and a drive enable. Read data comes back on a registered port, marked by a strobe that lasts one cycle.

Every strobe interval is a whole number of clock cycles. The counts come from a clock-period parameter and a speed-grade parameter (15, 17, 20, 25 or 35 ns). Each count is ceiling(ns / period) and is never less than one cycle. The write setup, pulse and data-setup counts are parameters of their own. Between accesses the memory is always deselected. After a read, the controller keeps its data drivers off until the memory's output has had time to float.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset and whenever no access is in progress, the select pair is in the deselected combination (active-low select high, active-high select low), output enable and write enable are high, the data drivers are off and, once any bus-release wait has ended, the request port is ready.
- R2: An accepted read makes the memory selected (active-low select low and active-high select high), with output enable low and write enable high, for exactly RD_CYC consecutive cycles starting the cycle after acceptance. RD_CYC is 3 at the default 15 ns grade and 5 ns clock.
- R3: The byte present on the data input during the last read cycle appears on the read-data port, and the read-valid strobe is high for exactly the one following cycle.
- R4: An accepted write keeps the memory selected and output enable high. Write enable stays high for AS_CYC cycles (default 1), is low for max(WP_CYC, DS_CYC) cycles (default 2), then is high for one hold cycle. Throughout these cycles the data drivers are on and carry the request's write data.
- R5: After a read deselects the memory, the request port stays not ready for HZ_CYC cycles (2 by default). The data drivers are never on while output enable is low, nor during those cycles.
- R6: While the memory stays selected, the address does not change. It takes a new value only at the edge where a deselected memory becomes selected.
- R7: The read length is max(ceil(grade / period), ceil(oe_time / period)) and HZ_CYC is ceil(float_time / period). Both times depend on the grade: 6 ns at 15, 7 ns at 17 and 20, 8 ns at 25 and 35. Every count is at least one.
- R8: The port is ready only when idle. A request held while not ready waits without being lost and is taken on the first ready cycle.
- R9: A byte written through the pins is returned unchanged by a later read of the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | 8 | Captured read byte |
| mem_addr | output | 17 | Memory address bus |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data driven toward memory |
| mem_dq_in | input | 8 | Data from memory |
| mem_dq_oe | output | 1 | Data driver enable |

## Verification
Two things can fall in the same cycle: the bus-release wait that follows a read, and a write request that arrives while the memory may still be driving the bus. The bench provokes this by issuing a write right behind a read, and it holds req_valid through the not-ready cycles. A cycle-by-cycle reference model then judges the result: it checks the exact cycle of acceptance, and it checks that the drivers stay off while the bench's memory model still counts its float window. A write followed by a read of the same address also overlaps the write hold cycle with the next selection, and the model checks that case as well.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_WSU,
      ST_WPL,
      ST_WHD
   } seq_state_t;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int ceil_cyc(input int ns, input int clk_ns);
      int r;
      r = (ns + clk_ns - 1) / clk_ns;
      if (r < 1) r = 1;
      return r;
   endfunction

   function automatic bit grade_ok(input int g);
      return (g == 15) || (g == 17) || (g == 20) || (g == 25) || (g == 35);
   endfunction

   // output-enable to data time for a grade
   function automatic int oe_ns_of(input int g);
      case (g)
         15:      return 6;
         17, 20:  return 7;
         default: return 8;
      endcase
   endfunction

   // time the part may keep driving after a deselect
   function automatic int hz_ns_of(input int g);
      case (g)
         15:      return 6;
         17, 20:  return 7;
         default: return 8;
      endcase
   endfunction

endpackage

// File: rtl/sram_seq.sv
module sram_seq import sram_ctrl_pkg::*; #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8,
   parameter int RD_CYC = 3,
   parameter int AS_CYC = 1,
   parameter int PL_CYC = 2,
   parameter int HZ_CYC = 2,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output seq_state_t        state_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              rd_last,
   output logic              hiz_zero
);

   localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] AS_LD = CNT_W'(AS_CYC - 1);
   localparam logic [CNT_W-1:0] PL_LD = CNT_W'(PL_CYC - 1);
   localparam logic [CNT_W-1:0] HZ_LD = CNT_W'(HZ_CYC);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] hiz_q;

   assign hiz_zero  = (hiz_q == '0);
   assign req_ready = (state_q == ST_IDLE) && hiz_zero;
   assign rd_last   = (state_q == ST_RD) && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         hiz_q   <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (!hiz_zero) hiz_q <= hiz_q - 1'b1;
               if (req_valid && req_ready) begin
                  addr_q  <= req_addr;
                  wdata_q <= req_wdata;
                  if (req_we) begin
                     state_q <= ST_WSU;
                     cnt_q   <= AS_LD;
                  end else begin
                     state_q <= ST_RD;
                     cnt_q   <= RD_LD;
                  end
               end
            end
            ST_RD: begin
               if (cnt_q == '0) begin
                  state_q <= ST_IDLE;
                  hiz_q   <= HZ_LD;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_WSU: begin
               if (cnt_q == '0) begin
                  state_q <= ST_WPL;
                  cnt_q   <= PL_LD;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_WPL: begin
               if (cnt_q == '0) state_q <= ST_WHD;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            ST_WHD:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // an accepted request always leaves the idle state
   assert_accept_leaves_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (state_q != ST_IDLE))
      else $error("accepted request did not start an access");

endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv import sram_ctrl_pkg::*; #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  seq_state_t        state_q,
   input  logic              rd_last,
   input  logic [DATA_W-1:0] wdata_q,
   input  logic [DATA_W-1:0] dq_in,
   output logic              ce1_n,
   output logic              ce2,
   output logic              oe_n,
   output logic              we_n,
   output logic              dq_oe,
   output logic [DATA_W-1:0] dq_out,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   logic sel;

   always_comb begin
      sel    = (state_q != ST_IDLE);
      ce1_n  = ~sel;
      ce2    = sel;
      oe_n   = (state_q != ST_RD);
      we_n   = (state_q != ST_WPL);
      dq_oe  = (state_q == ST_WSU) || (state_q == ST_WPL) || (state_q == ST_WHD);
      dq_out = wdata_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_last;
         if (rd_last) rd_data <= dq_in;
      end
   end

   assert_rvalid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid)
      else $error("read-valid strobe longer than one cycle");

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl import sram_ctrl_pkg::*; #(
   parameter int ADDR_W   = 17,
   parameter int DATA_W   = 8,
   parameter int CLK_NS   = 5,
   parameter int GRADE_NS = 15,
   parameter int AS_CYC   = 1,
   parameter int WP_CYC   = 2,
   parameter int DS_CYC   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce1_n,
   output logic              mem_ce2,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_dq_oe
);

   localparam int ACC_CYC = ceil_cyc(GRADE_NS, CLK_NS);
   localparam int OE_CYC  = ceil_cyc(oe_ns_of(GRADE_NS), CLK_NS);
   localparam int RD_CYC  = max_int(ACC_CYC, OE_CYC);
   localparam int HZ_CYC  = ceil_cyc(hz_ns_of(GRADE_NS), CLK_NS);
   localparam int PL_CYC  = max_int(WP_CYC, DS_CYC);
   localparam int CNT_MAX = max_int(max_int(RD_CYC, PL_CYC), max_int(AS_CYC, HZ_CYC));
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   generate
      if (!grade_ok(GRADE_NS)) begin : g_bad_grade
         $error("GRADE_NS must be 15, 17, 20, 25 or 35");
      end
      if (CLK_NS < 1 || AS_CYC < 1 || WP_CYC < 1 || DS_CYC < 1) begin : g_bad_cnt
         $error("clock period and write counts must be at least 1");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("bus widths must be positive");
      end
   endgenerate

   seq_state_t        state_q;
   logic [DATA_W-1:0] wdata_q;
   logic              rd_last;
   logic              hiz_zero;

   sram_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .RD_CYC (RD_CYC),
      .AS_CYC (AS_CYC),
      .PL_CYC (PL_CYC),
      .HZ_CYC (HZ_CYC),
      .CNT_W  (CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_we    (req_we),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_ready (req_ready),
      .state_q   (state_q),
      .addr_q    (mem_addr),
      .wdata_q   (wdata_q),
      .rd_last   (rd_last),
      .hiz_zero  (hiz_zero)
   );

   sram_pin_drv #(
      .DATA_W (DATA_W)
   ) u_pins (
      .clk      (clk),
      .rst_n    (rst_n),
      .state_q  (state_q),
      .rd_last  (rd_last),
      .wdata_q  (wdata_q),
      .dq_in    (mem_dq_in),
      .ce1_n    (mem_ce1_n),
      .ce2      (mem_ce2),
      .oe_n     (mem_oe_n),
      .we_n     (mem_we_n),
      .dq_oe    (mem_dq_oe),
      .dq_out   (mem_dq_out),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe))
      else $error("ready while memory still selected or driven");

   assert_write_masks_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce1_n && mem_ce2))
      else $error("write strobe without select, drivers or with output enable");

   assert_no_fight_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_dq_oe)
      else $error("drivers on while memory outputs enabled");

   assert_drive_after_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> hiz_zero)
      else $error("drivers on inside bus-release window");

   assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr))
      else $error("address moved while selected");

endmodule

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/100ps
module sram_async_ctrl_bench;

   // hand-derived counts for 15 ns grade, 5 ns clock (R7)
   localparam int N_RD = 3;
   localparam int N_AS = 1;
   localparam int N_PL = 2;
   localparam int N_HZ = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_we = 1'b0;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rd_valid;
   logic [7:0]  rd_data;
   logic [16:0] mem_addr;
   logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [7:0]  mem_dq_out, mem_dq_in;

   int nchk = 0;
   int nfail = 0;
   bit mon_en = 0;
   bit done = 0;

   logic [7:0] mem [256];
   logic [7:0] shadow [256];
   bit         written [256];

   always #2.5 clk = ~clk;

   sram_async_ctrl u_sram_async_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
      .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
      .mem_dq_oe(mem_dq_oe));

   // memory model: drives only when selected, reading; junk otherwise
   assign mem_dq_in = (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n)
                      ? mem[mem_addr[7:0]] : (8'h5A ^ mem_addr[7:0]);

   always @(posedge mem_we_n)
      if (!mem_ce1_n && mem_ce2 && mem_dq_oe) mem[mem_addr[7:0]] <= mem_dq_out;

   typedef struct {
      bit          sel, oe_n, we_n, drv, chk_addr, rdy, rv;
      logic [16:0] addr;
      logic [7:0]  dout, rd;
      string       tag, rtag;
   } exp_t;

   exp_t q[$];

   function automatic exp_t idle_e();
      exp_t e;
      e.sel = 0; e.oe_n = 1; e.we_n = 1; e.drv = 0; e.chk_addr = 0;
      e.rdy = 1; e.rv = 0; e.addr = '0; e.dout = '0; e.rd = '0;
      e.tag = "R1"; e.rtag = "R3";
      return e;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   int mem_left = 0;

   // reference model compared once per cycle, mid-cycle
   always begin
      @(negedge clk); #1;
      if (mon_en && !done) begin
         exp_t e;
         if (q.size() > 0) e = q.pop_front(); else e = idle_e();
         chk({!mem_ce1_n, mem_ce2} == {e.sel, e.sel}, e.tag, "select pair",
             {!mem_ce1_n, mem_ce2}, {e.sel, e.sel});
         chk(mem_oe_n == e.oe_n, e.tag, "oe_n", mem_oe_n, e.oe_n);
         chk(mem_we_n == e.we_n, e.tag, "we_n", mem_we_n, e.we_n);
         chk(mem_dq_oe == e.drv, e.tag, "dq_oe", mem_dq_oe, e.drv);
         chk(req_ready == e.rdy, "R8", "ready", req_ready, e.rdy);
         chk(rd_valid == e.rv, e.rtag, "rd_valid", rd_valid, e.rv);
         if (e.chk_addr) chk(mem_addr == e.addr, "R6", "addr", mem_addr, e.addr);
         if (e.drv) chk(mem_dq_out == e.dout, "R4", "dq_out", mem_dq_out, e.dout);
         if (e.rv) chk(rd_data == e.rd, e.rtag, "rd_data", rd_data, e.rd);
         // R5: no drive while memory can still be driving
         if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n) begin
            chk(!mem_dq_oe, "R5", "drive during read", mem_dq_oe, 0);
            mem_left = N_HZ;
         end else if (mem_left > 0) begin
            chk(!mem_dq_oe, "R5", "drive in float window", mem_dq_oe, 0);
            mem_left--;
         end
         if (req_valid && req_ready) begin
            exp_t n;
            n = idle_e();
            n.sel = 1; n.rdy = 0; n.chk_addr = 1; n.addr = req_addr;
            if (req_we) begin
               n.drv = 1; n.dout = req_wdata; n.tag = "R4";
               for (int i = 0; i < N_AS; i++) q.push_back(n);
               n.we_n = 0;
               for (int i = 0; i < N_PL; i++) q.push_back(n);
               n.we_n = 1;
               q.push_back(n);
               shadow[req_addr[7:0]] = req_wdata;
               written[req_addr[7:0]] = 1;
            end else begin
               n.oe_n = 0; n.tag = "R2";
               for (int i = 0; i < N_RD - 1; i++) q.push_back(n);
               n.tag = "R7";
               q.push_back(n);
               n = idle_e();
               n.rdy = 0; n.tag = "R5";
               for (int i = 0; i < N_HZ; i++) begin
                  n.rv = (i == 0);
                  n.rd = shadow[req_addr[7:0]];
                  n.rtag = written[req_addr[7:0]] ? "R9" : "R3";
                  q.push_back(n);
               end
            end
         end
      end
   end

   task automatic issue(input bit we, input logic [16:0] a, input logic [7:0] d);
      bit got;
      @(negedge clk);
      req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
      got = 0;
      while (!got) begin
         #1; got = req_ready;
         @(posedge clk);
      end
      #1 req_valid = 0;
   endtask

   task automatic drain();
      while (q.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i] = 8'(i * 7 + 3);
         shadow[i] = 8'(i * 7 + 3);
         written[i] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid,
          "R1", "reset pins", {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
      rst_n = 1;
      mon_en = 1;
      repeat (2) @(negedge clk);
      issue(0, 17'h12345, 8'h00);            // R2/R3 plain read
      drain();
      issue(1, 17'h00010, 8'hC3);            // R4 write
      issue(0, 17'h00010, 8'h00);            // R9 back-to-back readback
      drain();
      issue(0, 17'h0AA77, 8'h00);            // R5: write right behind read
      issue(1, 17'h1FFFF, 8'h96);
      issue(1, 17'h00000, 8'h3C);
      issue(0, 17'h1FFFF, 8'h00);            // R9 all-ones address
      issue(0, 17'h00000, 8'h00);            // R8 read held while not ready
      issue(1, 17'h0AA77, 8'h5E);
      repeat (4) @(negedge clk);             // R1 idle gap
      issue(0, 17'h0AA77, 8'h00);
      drain();
      finish_run();
   end

   initial begin
      for (int c = 0; c < 5000; c++) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

endmodule